// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer that counts a free-running tick. Software must restart it before the selected timeout passes. If it does not, the block raises a reset request that lasts exactly one clock cycle. The timeout is a power of two: 2^(BASE_EXP+n) ticks, where n is a 3-bit scale field.

The control path has three fields: an enable bit, a change-enable bit and the scale field. Turning the watchdog off, and in most cases changing its timeout, is accepted only inside a short timed window. Software opens this window by writing the change-enable and enable bits as one together in a single write. A two-bit static safety input selects one of three protection levels. The level decides what the window is needed for and whether the watchdog can be turned off at all.

The surrounding system drives `safety_cfg` before reset and holds it steady afterwards. The system reset sequencer consumes `wd_rst`.

Top module: `wdt_guard`

## Requirements
- R1: After reset the scale is 0, the change-enable flag is 0 and no reset request is present. The enable bit resets to 1 at level 2 and to 0 at the other levels. `safety_cfg` 0 selects level 0, 1 selects level 1, and 2 or 3 select level 2.
- R2: While enabled, `wd_rst` rises on the 2^(BASE_EXP+n) th tick after the last restart or the last expiry, where n is the scale. Cycles without a tick are not counted, and the count starts again from zero after each expiry.
- R3: Each expiry produces a reset request exactly one clock cycle wide.
- R4: A restart pulse clears the count. A restart in the same cycle as the final tick wins, so no reset request follows.
- R5: A write with change-enable = 1 and enable = 1 opens a window. `wd_chg` reads 1 in the four cycles after that write and then clears by itself. This works even when the enable bit is already 1.
- R6: A write with change-enable = 0 sampled in any of the four cycles after the opening write is a privileged change, and it closes the window. The same write one cycle later gets no privilege.
- R7: At level 0, writes may set the enable bit and change the scale at any time. Clearing the enable bit needs the window.
- R8: At level 1, writes may set the enable bit at any time. Clearing it or changing the scale needs the window, and otherwise both stay unchanged.
- R9: At level 2 the enable bit is always 1, even for a write inside the window. The scale changes only inside the window.
- R10: A write with change-enable = 1 and enable = 0 leaves the enable bit, the scale and the window unchanged.
- R11: While disabled, the count stays at zero and no reset request is raised.
- R12: If the scale is lowered below the ticks already counted, a reset request follows on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the free-running time base |
| kick | input | 1 | One-cycle restart pulse |
| safety_cfg | input | 2 | Static protection level select |
| ctl_wr | input | 1 | Control write strobe |
| ctl_chg | input | 1 | Written change-enable bit |
| ctl_en | input | 1 | Written enable bit |
| ctl_scale | input | SCALE_W | Written timeout scale |
| wd_en | output | 1 | Current enable bit |
| wd_chg | output | 1 | Change window open |
| wd_scale | output | SCALE_W | Current timeout scale |
| wd_rst | output | 1 | One-cycle reset request |

## Verification
Restart and expiry can fall in the same cycle. The bench provokes this by counting exactly one tick short of the timeout and then holding `kick` across the edge that carries the final tick. It then checks that `wd_rst` stays low and that a full new timeout follows. Scale update and counting can also coincide: the scale is lowered to below the elapsed count while ticks keep running, and the bench expects the reset request one cycle after the write. The window boundaries are swept one cycle at a time at level 1 to check that the fourth cycle is accepted and the fifth is refused.

// File: rtl/wdt_pkg.sv
// Shared types for the guarded watchdog.
// Assumes the safety configuration is static while out of reset.
package wdt_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN   = 2'd0,
        LVL_GUARD  = 2'd1,
        LVL_LOCKED = 2'd2
    } wdt_level_e;

    // Map the two static configuration bits onto a protection level.
    function automatic wdt_level_e decode_level(input logic [1:0] cfg);
        if (cfg == 2'd0)      return LVL_OPEN;
        else if (cfg == 2'd1) return LVL_GUARD;
        else                  return LVL_LOCKED;
    endfunction

endpackage

// File: rtl/wdt_ctl.sv
// Control register with timed unlock window.
// Holds enable, scale and window counter; applies the level rules to every write.
// Assumes level is static while rst_n is high.
module wdt_ctl
    import wdt_pkg::*;
#(
    parameter int SCALE_W = 3,
    parameter int WIN_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wdt_level_e         level,
    input  logic               wr,
    input  logic               wr_chg,
    input  logic               wr_en,
    input  logic [SCALE_W-1:0] wr_scale,
    output logic               en_o,
    output logic               chg_o,
    output logic [SCALE_W-1:0] scale_o
);
    localparam int WIN_W = $clog2(WIN_LEN + 1);

    logic               en_q, en_n;
    logic [SCALE_W-1:0] scale_q, scale_n;
    logic [WIN_W-1:0]   win_q, win_n;
    logic               win_open, unlock, plain;

    assign win_open = (win_q != '0);
    assign unlock   = wr && wr_chg && wr_en;
    assign plain    = wr && !wr_chg;

    // Next-state rules for enable, scale and window per protection level.
    always_comb begin
        en_n    = en_q;
        scale_n = scale_q;
        win_n   = win_open ? win_q - 1'b1 : '0;
        if (unlock) begin
            win_n = WIN_W'(WIN_LEN);
            if (level != LVL_LOCKED) en_n = 1'b1;
            if (level == LVL_OPEN)   scale_n = wr_scale;
        end else if (plain) begin
            if (wr_en)
                en_n = 1'b1;
            else if (win_open && level != LVL_LOCKED)
                en_n = 1'b0;
            if (win_open || level == LVL_OPEN)
                scale_n = wr_scale;
            if (win_open)
                win_n = '0;
        end
        if (level == LVL_LOCKED) en_n = 1'b1;
    end

    // Register the control state; enable comes out of reset per level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= (level == LVL_LOCKED);
            scale_q <= '0;
            win_q   <= '0;
        end else begin
            en_q    <= en_n;
            scale_q <= scale_n;
            win_q   <= win_n;
        end
    end

    assign en_o    = en_q;
    assign chg_o   = win_open;
    assign scale_o = scale_q;

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (en_q && !win_open) |=> en_q); // R8
    AST_LOCKED_ON: assert property (@(posedge clk) disable iff (!rst_n) (level == LVL_LOCKED) |-> en_q); // R9
    AST_SCALE_GUARD: assert property (@(posedge clk) disable iff (!rst_n) (level != LVL_OPEN && !win_open) |=> $stable(scale_q)); // R8
    AST_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr && wr_chg && !wr_en) |=> ($stable(en_q) && $stable(scale_q))); // R10
    AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) (win_open && plain) |=> !win_open); // R6

endmodule

// File: rtl/wdt_cnt.sv
// Tick counter, timeout compare and one-cycle reset pulse.
// Timeout for scale n is 2^(BASE_EXP+n) ticks; restart wins over expiry.
// Assumes BASE_EXP >= 1 so every timeout is at least two ticks.
module wdt_cnt #(
    parameter int BASE_EXP = 14,
    parameter int SCALE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               kick,
    input  logic [SCALE_W-1:0] scale,
    output logic               rst_req
);
    localparam int N_SCALE = 1 << SCALE_W;
    localparam int CNT_W   = BASE_EXP + N_SCALE - 1;
    localparam logic [CNT_W:0] ONE = 1;

    logic [CNT_W-1:0] lim_tab [N_SCALE];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic             expire;
    logic             pulse_q;

    // Build the last-count value for each scale setting.
    for (genvar g = 0; g < N_SCALE; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'((ONE << (BASE_EXP + g)) - ONE);
    end

    assign lim_m1 = lim_tab[scale];
    assign expire = en && tick && !kick && (cnt_q >= lim_m1);

    // Advance the count on ticks; clear on restart, expiry or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire;
            if (!en || kick || expire)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign rst_req = pulse_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R3
    AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n) kick |=> !rst_req); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !rst_req); // R11

endmodule

// File: rtl/wdt_guard.sv
// Guarded watchdog top: protected control register plus timeout counter.
// Assumes safety_cfg is held static outside reset and tick is synchronous to clk.
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 14,
    parameter int SCALE_W  = 3,
    parameter int WIN_LEN  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               kick,
    input  logic [1:0]         safety_cfg,
    input  logic               ctl_wr,
    input  logic               ctl_chg,
    input  logic               ctl_en,
    input  logic [SCALE_W-1:0] ctl_scale,
    output logic               wd_en,
    output logic               wd_chg,
    output logic [SCALE_W-1:0] wd_scale,
    output logic               wd_rst
);
    wdt_level_e lvl;

    assign lvl = decode_level(safety_cfg);

    wdt_ctl #(.SCALE_W(SCALE_W), .WIN_LEN(WIN_LEN)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lvl),
        .wr       (ctl_wr),
        .wr_chg   (ctl_chg),
        .wr_en    (ctl_en),
        .wr_scale (ctl_scale),
        .en_o     (wd_en),
        .chg_o    (wd_chg),
        .scale_o  (wd_scale)
    );

    wdt_cnt #(.BASE_EXP(BASE_EXP), .SCALE_W(SCALE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wd_en),
        .tick    (tick),
        .kick    (kick),
        .scale   (wd_scale),
        .rst_req (wd_rst)
    );

endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       kick = 1'b0;
    logic [1:0] safety_cfg = 2'd0;
    logic       ctl_wr = 1'b0, ctl_chg = 1'b0, ctl_en = 1'b0;
    logic [2:0] ctl_scale = 3'd0;
    logic       wd_en, wd_chg, wd_rst;
    logic [2:0] wd_scale;

    int checked = 0;
    int failed  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard #(.BASE_EXP(BASE), .SCALE_W(3), .WIN_LEN(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .safety_cfg(safety_cfg),
        .ctl_wr(ctl_wr), .ctl_chg(ctl_chg), .ctl_en(ctl_en), .ctl_scale(ctl_scale),
        .wd_en(wd_en), .wd_chg(wd_chg), .wd_scale(wd_scale), .wd_rst(wd_rst)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checked++;
        if (act != exp_v) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic do_reset(input logic [1:0] cfg);
        @(negedge clk);
        safety_cfg = cfg; rst_n = 1'b0; ctl_wr = 1'b0; kick = 1'b0; tick = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic c, input logic e, input logic [2:0] s);
        ctl_wr = 1'b1; ctl_chg = c; ctl_en = e; ctl_scale = s;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic measure(input logic slow, output int n);
        int guard = 0;
        n = 0;
        while (!wd_rst && guard < 5000) begin
            if (slow) tick = ~tick;
            if (tick) n++;
            @(negedge clk);
            guard++;
        end
        tick = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++; checked++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checked, failed);
        $finish;
    end

    initial begin
        int n;
        int hits;
        logic [2:0] exp_sc;

        // ---------- level 0 ----------
        do_reset(2'd0);
        chk("R1 en L0", wd_en, 0);
        chk("R1 scale", wd_scale, 0);
        chk("R1 chg", wd_chg, 0);
        chk("R1 rst", wd_rst, 0);
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wd_rst) hits++;
        end
        chk("R11 no request while disabled", hits, 0);

        wr(1'b0, 1'b1, 3'd3);
        chk("R7 free enable", wd_en, 1);
        chk("R7 free scale", wd_scale, 3);
        wr(1'b0, 1'b0, 3'd3);
        chk("R7 disable outside window ignored", wd_en, 1);
        wr(1'b1, 1'b0, 3'd6);
        chk("R10 bad write en", wd_en, 1);
        chk("R10 bad write scale", wd_scale, 3);
        chk("R10 bad write chg", wd_chg, 0);

        // R2/R3 sweep of every scale, two periods each
        for (int s = 0; s < 8; s++) begin
            wr(1'b0, 1'b1, 3'(s));
            do_kick();
            measure(1'b0, n);
            chk($sformatf("R2 timeout scale %0d", s), n, 1 << (BASE + s));
            @(negedge clk);
            chk("R3 pulse width", wd_rst, 0);
            do_kick();
            measure(1'b0, n);
            @(negedge clk);
            measure(1'b0, n);
            chk($sformatf("R2 restart after expiry scale %0d", s), n + 1, 1 << (BASE + s));
        end

        // R2 with gapped ticks
        wr(1'b0, 1'b1, 3'd1);
        do_kick();
        measure(1'b1, n);
        chk("R2 gapped ticks", n, 8);

        // R4 restart on the final tick
        wr(1'b0, 1'b1, 3'd0);
        do_kick();
        repeat (3) @(negedge clk);
        do_kick();
        chk("R4 restart beats expiry", wd_rst, 0);
        measure(1'b0, n);
        chk("R4 full period after restart", n, 4);

        // R12 scale lowered below elapsed count
        wr(1'b0, 1'b1, 3'd3);
        do_kick();
        repeat (10) @(negedge clk);
        wr(1'b0, 1'b1, 3'd0);
        chk("R12 not yet", wd_rst, 0);
        @(negedge clk);
        chk("R12 next tick expires", wd_rst, 1);

        // R7 disable through window at level 0
        wr(1'b1, 1'b1, 3'd0);
        wr(1'b0, 1'b0, 3'd0);
        chk("R7 disable inside window", wd_en, 0);

        // ---------- level 1 ----------
        do_reset(2'd1);
        chk("R1 en L1", wd_en, 0);
        wr(1'b0, 1'b1, 3'd6);
        chk("R8 free enable", wd_en, 1);
        chk("R8 scale refused", wd_scale, 0);
        wr(1'b0, 1'b0, 3'd0);
        chk("R8 disable refused", wd_en, 1);
        wr(1'b1, 1'b0, 3'd5);
        chk("R10 bad write L1 en", wd_en, 1);
        chk("R10 bad write L1 scale", wd_scale, 0);

        wr(1'b1, 1'b1, 3'd0);
        for (int i = 0; i < 5; i++) begin
            chk($sformatf("R5 window cycle %0d", i), wd_chg, (i < 4) ? 1 : 0);
            @(negedge clk);
        end

        exp_sc = 3'd0;
        for (int k = 0; k < 6; k++) begin
            wr(1'b1, 1'b1, 3'd7);
            chk("R5 unlock with enable set", wd_chg, 1);
            repeat (k) @(negedge clk);
            wr(1'b0, 1'b0, 3'(k + 1));
            if (k <= 3) begin
                exp_sc = 3'(k + 1);
                chk($sformatf("R6 disable at offset %0d", k), wd_en, 0);
            end else begin
                chk($sformatf("R6 late write offset %0d", k), wd_en, 1);
            end
            chk($sformatf("R6 scale offset %0d", k), wd_scale, exp_sc);
            chk("R6 window closed", wd_chg, 0);
            wr(1'b0, 1'b1, 3'd0);
        end

        // ---------- level 2 ----------
        do_reset(2'd2);
        chk("R1 en L2", wd_en, 1);
        wr(1'b0, 1'b0, 3'd4);
        chk("R9 disable refused", wd_en, 1);
        chk("R9 scale refused outside", wd_scale, 0);
        wr(1'b1, 1'b1, 3'd0);
        wr(1'b0, 1'b0, 3'd4);
        chk("R9 disable refused in window", wd_en, 1);
        chk("R9 scale in window", wd_scale, 4);
        do_kick();
        measure(1'b0, n);
        chk("R9 R2 timeout at level 2", n, 64);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checked, failed);
        $finish;
    end
endmodule